// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower backing memory. It keeps 256 lines of 32 bytes each, and each line records a valid flag and a 21-bit tag. A 34-bit byte address is decoded into three fields. Bits [33:13] are the tag. Bits [12:5] pick the line. Bits [4:3] select one of four 64-bit words inside the block. Every block address has exactly one possible line, so there is no victim choice: a fill always overwrites whatever the indexed line held.

A load that finds its line valid, with a matching tag, returns the word one cycle after it is accepted. A load that misses requests the whole block from backing memory. The block arrives as four 64-bit beats, word 0 first. The beats are written into the line, the tag and valid flag are set, and the word is then read back out of the cache and delivered. Stores never set any state that must later be copied back. Every store goes out to an external write buffer. A store that hits also merges its enabled bytes into the line. A store that misses leaves the cache untouched. While the write buffer reports full, the processor is held off from issuing a store.

Top module: `dcache_wt`

## Requirements
- R1: The line index is cpu_addr[12:5], the stored tag is cpu_addr[33:13] and the word within the line is cpu_addr[4:3]; two addresses that differ only in bits [4:0] share a line.
- R2: Synchronous reset (rst high at a clock edge) invalidates every line, so the first load to any address after reset is a miss; during and right after reset cpu_rvalid, mem_rd_req and wb_push are low.
- R3: A load accepted (cpu_req and cpu_ready high, cpu_we low) at clock edge N that hits drives cpu_rvalid high with the addressed 64-bit word on cpu_rdata in the cycle after edge N.
- R4: A load that misses raises mem_rd_req for exactly one cycle with mem_rd_addr equal to the 32-byte-aligned block address. It then takes four beats flagged by mem_rd_valid, in the order word 0 to word 3, and afterwards delivers the requested word from the refilled line.
- R5: A load to a line held under a different tag is a miss and replaces the line, so the previous block then misses as well.
- R6: Every accepted store produces one wb_push pulse in the cycle after acceptance, carrying the store's address, data and byte enables, whether it hits or misses.
- R7: A store hit changes only the bytes whose cpu_be bit is set (bit i covers data bits 8i+7 to 8i); later loads to that word return the merged value.
- R8: A store miss fetches nothing from backing memory and does not change any line: a block resident in that line before the store still hits afterwards with unchanged data.
- R9: While wb_full is high, cpu_ready is low for a store request and no wb_push occurs; loads are still accepted.
- R10: Each accepted load yields exactly one cpu_rvalid cycle.
- R11: cpu_ready is low whenever a lookup, refill or re-read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 34 | Byte address |
| cpu_wdata | input | 64 | Store data |
| cpu_be | input | 8 | Store byte enables |
| cpu_ready | output | 1 | Request accepted at this edge when high with cpu_req |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 64 | Load data |
| mem_rd_req | output | 1 | One-cycle block fetch request |
| mem_rd_addr | output | 34 | Block-aligned fetch address |
| mem_rd_valid | input | 1 | Fetch beat valid |
| mem_rd_data | input | 64 | Fetch beat data |
| wb_full | input | 1 | Write buffer cannot take a store |
| wb_push | output | 1 | Store handed to the write buffer |
| wb_addr | output | 34 | Store address |
| wb_data | output | 64 | Store data |
| wb_be | output | 8 | Store byte enables |

## Verification
The checker watches, on every cycle, the properties that concern handshake shape. A fetch request lasts one cycle and is block-aligned. A push only follows an accepted store made while the buffer had room. A push never coincides with a fetch. Each load yields one response, and no request is accepted during a response. Only the bench can show which data comes back and when. It checks hit-versus-miss latency, byte-merged store hits, stores that miss and leave the line intact, conflict eviction between two tags on one index, the extreme index and tag values, and invalidation by reset.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    DC_IDLE,
    DC_CMP,
    DC_FILL,
    DC_RD
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int TAG_W = 21,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic [TAG_W-1:0] chk_tag,
  output logic             hit
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [TAG_W-1:0] tag_q;
  logic [LINES-1:0] valid_q;

  // block-RAM style tag array: synchronous read, no reset
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    tag_q <= tag_mem[rd_idx];
  end

  // valid flags live in flops so reset can clear all of them at once
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  assign hit = valid_q[chk_idx] && (tag_q == chk_tag);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int WORD_W = 64,
  parameter int AW     = 10
) (
  input  logic                clk,
  input  logic [AW-1:0]       addr,
  input  logic                we,
  input  logic [WORD_W/8-1:0] be,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata
);
  localparam int LANES = WORD_W / 8;
  localparam int DEPTH = 1 << AW;

  // one byte-wide RAM per lane keeps byte-enable writes inferable
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (we && be[b]) lane_mem[addr] <= wdata[8*b +: 8];
      lane_q <= lane_mem[addr];
    end
    assign rdata[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int TAG_W  = 21,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 5,
  parameter int WORD_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0]           cpu_wdata,
  input  logic [WORD_W/8-1:0]         cpu_be,
  output logic                        cpu_ready,
  output logic                        cpu_rvalid,
  output logic                        mem_rd_req,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_rd_addr,
  input  logic                        mem_rd_valid,
  input  logic [WORD_W-1:0]           mem_rd_data,
  input  logic                        wb_full,
  output logic                        wb_push,
  output logic [TAG_W+IDX_W+OFF_W-1:0] wb_addr,
  output logic [WORD_W-1:0]           wb_data,
  output logic [WORD_W/8-1:0]         wb_be,
  input  logic                        hit,
  output logic [IDX_W-1:0]            tag_rd_idx,
  output logic                        tag_wr_en,
  output logic [IDX_W-1:0]            tag_wr_idx,
  output logic [TAG_W-1:0]            tag_wr_tag,
  output logic [IDX_W-1:0]            chk_idx,
  output logic [TAG_W-1:0]            chk_tag,
  output logic [IDX_W+$clog2((1<<OFF_W)/(WORD_W/8))-1:0] dat_addr,
  output logic                        dat_we,
  output logic [WORD_W/8-1:0]         dat_be,
  output logic [WORD_W-1:0]           dat_wdata
);
  localparam int ADDR_W   = TAG_W + IDX_W + OFF_W;
  localparam int BYTES    = WORD_W / 8;
  localparam int WSEL_LSB = $clog2(BYTES);
  localparam int BEATS    = (1 << OFF_W) / BYTES;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int IDX_LSB  = OFF_W;
  localparam int TAG_LSB  = OFF_W + IDX_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  dc_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  req_addr_q;
  logic               req_we_q;
  logic [WORD_W-1:0]  req_wdata_q;
  logic [BYTES-1:0]   req_be_q;
  logic [BEAT_W-1:0]  beat_q;
  logic               accept;
  logic               last_beat;

  logic [IDX_W-1:0]   cpu_idx, req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [BEAT_W-1:0]  cpu_wsel, req_wsel;

  assign cpu_idx  = cpu_addr[TAG_LSB-1:IDX_LSB];
  assign cpu_wsel = cpu_addr[OFF_W-1:WSEL_LSB];
  assign req_idx  = req_addr_q[TAG_LSB-1:IDX_LSB];
  assign req_tag  = req_addr_q[ADDR_W-1:TAG_LSB];
  assign req_wsel = req_addr_q[OFF_W-1:WSEL_LSB];

  assign cpu_ready = (state_q == DC_IDLE) && !(cpu_we && wb_full);
  assign accept    = cpu_req && cpu_ready;
  assign last_beat = (state_q == DC_FILL) && mem_rd_valid && (beat_q == LAST_BEAT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DC_IDLE: if (accept) state_d = DC_CMP;
      DC_CMP:  state_d = (req_we_q || hit) ? DC_IDLE : DC_FILL;
      DC_FILL: if (last_beat) state_d = DC_RD;
      DC_RD:   state_d = DC_CMP;
      default: state_d = DC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= DC_IDLE;
      beat_q     <= '0;
      mem_rd_req <= 1'b0;
      wb_push    <= 1'b0;
    end else begin
      state_q    <= state_d;
      mem_rd_req <= (state_q == DC_CMP) && !req_we_q && !hit;
      wb_push    <= accept && cpu_we;
      if (state_q == DC_CMP) beat_q <= '0;
      else if ((state_q == DC_FILL) && mem_rd_valid) beat_q <= beat_q + 1'b1;
    end
  end

  // request capture and write-buffer handoff registers
  always_ff @(posedge clk) begin
    if (accept) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
      req_be_q    <= cpu_be;
      wb_addr     <= cpu_addr;
      wb_data     <= cpu_wdata;
      wb_be       <= cpu_be;
    end
    if ((state_q == DC_CMP) && !req_we_q && !hit)
      mem_rd_addr <= {req_tag, req_idx, {OFF_W{1'b0}}};
  end

  assign cpu_rvalid = (state_q == DC_CMP) && !req_we_q && hit;

  // tag array access
  assign tag_rd_idx = (state_q == DC_IDLE) ? cpu_idx : req_idx;
  assign tag_wr_en  = last_beat;
  assign tag_wr_idx = req_idx;
  assign tag_wr_tag = req_tag;
  assign chk_idx    = req_idx;
  assign chk_tag    = req_tag;

  // data array access: one port, shared by lookup, fill and store merge
  always_comb begin
    dat_we    = 1'b0;
    dat_be    = '1;
    dat_wdata = req_wdata_q;
    dat_addr  = {req_idx, req_wsel};
    unique case (state_q)
      DC_IDLE: dat_addr = {cpu_idx, cpu_wsel};
      DC_FILL: begin
        dat_addr  = {req_idx, beat_q};
        dat_we    = mem_rd_valid;
        dat_wdata = mem_rd_data;
      end
      DC_CMP: begin
        dat_we = req_we_q && hit;
        dat_be = req_be_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int TAG_W  = 21,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 5,
  parameter int WORD_W = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  input  logic [WORD_W/8-1:0]          cpu_be,
  output logic                         cpu_ready,
  output logic                         cpu_rvalid,
  output logic [WORD_W-1:0]            cpu_rdata,
  output logic                         mem_rd_req,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_rd_addr,
  input  logic                         mem_rd_valid,
  input  logic [WORD_W-1:0]            mem_rd_data,
  input  logic                         wb_full,
  output logic                         wb_push,
  output logic [TAG_W+IDX_W+OFF_W-1:0] wb_addr,
  output logic [WORD_W-1:0]            wb_data,
  output logic [WORD_W/8-1:0]          wb_be
);
  localparam int BYTES  = WORD_W / 8;
  localparam int BEATS  = (1 << OFF_W) / BYTES;
  localparam int DAT_AW = IDX_W + $clog2(BEATS);

  logic             hit;
  logic [IDX_W-1:0] tag_rd_idx, tag_wr_idx, chk_idx;
  logic [TAG_W-1:0] tag_wr_tag, chk_tag;
  logic             tag_wr_en;
  logic [DAT_AW-1:0] dat_addr;
  logic             dat_we;
  logic [BYTES-1:0] dat_be;
  logic [WORD_W-1:0] dat_wdata;

  dc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .wb_full(wb_full), .wb_push(wb_push), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_be(wb_be),
    .hit(hit),
    .tag_rd_idx(tag_rd_idx), .tag_wr_en(tag_wr_en),
    .tag_wr_idx(tag_wr_idx), .tag_wr_tag(tag_wr_tag),
    .chk_idx(chk_idx), .chk_tag(chk_tag),
    .dat_addr(dat_addr), .dat_we(dat_we), .dat_be(dat_be), .dat_wdata(dat_wdata)
  );

  dc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) i_tags (
    .clk(clk), .rst(rst),
    .rd_idx(tag_rd_idx),
    .wr_en(tag_wr_en), .wr_idx(tag_wr_idx), .wr_tag(tag_wr_tag),
    .chk_idx(chk_idx), .chk_tag(chk_tag),
    .hit(hit)
  );

  dc_data_store #(.WORD_W(WORD_W), .AW(DAT_AW)) i_data (
    .clk(clk), .addr(dat_addr), .we(dat_we), .be(dat_be),
    .wdata(dat_wdata), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
  parameter int ADDR_W = 34,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              wb_full,
  input logic              wb_push
);
  // R4: fetch request is a single-cycle pulse
  assert_fetch_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  // R4: fetch address is block aligned
  assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

  // R9: a push never follows a cycle where the buffer was full
  assert_push_room_R9: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> $past(!wb_full));

  // R6: a push only follows an accepted store
  assert_push_source_R6: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> $past(cpu_req && cpu_we && cpu_ready));

  // R8: a store never starts a block fetch
  assert_store_no_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> !mem_rd_req);

  // R10: one response cycle per load
  assert_single_resp_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);

  // R11: nothing is accepted while a response is driven
  assert_busy_on_resp_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> !cpu_ready);
endmodule

bind dcache_wt dcache_wt_chk #(.ADDR_W(TAG_W+IDX_W+OFF_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
  .wb_full(wb_full), .wb_push(wb_push)
);

// File: tb/test_dcache_wt.sv
module test_dcache_wt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [33:0] cpu_addr = '0;
  logic [63:0] cpu_wdata = '0;
  logic [7:0]  cpu_be = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [63:0] cpu_rdata;
  logic        mem_rd_req;
  logic [33:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        wb_full = 1'b0;
  logic        wb_push;
  logic [33:0] wb_addr;
  logic [63:0] wb_data;
  logic [7:0]  wb_be;

  int checks = 0, fails = 0, fills = 0;
  logic [33:0] fill_addr = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dcache_wt i_dcache_wt (.*);

  // backing memory contents: a fixed pattern of the word address
  function automatic logic [63:0] mem_word(logic [33:0] a);
    return {a[33:2], a[31:0]};
  endfunction

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nw, logic [7:0] be);
    logic [63:0] r = old;
    for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  typedef struct packed {
    logic        wr;
    logic [33:0] addr;
    logic [63:0] wd;
    logic [7:0]  be;
    logic        miss;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 34'h0A060, 64'h0, 8'h00, 1'b1, mem_word(34'h0A060)},                 // R4 first touch
    '{1'b0, 34'h0A068, 64'h0, 8'h00, 1'b0, mem_word(34'h0A068)},                 // R1/R3 same line
    '{1'b1, 34'h0A068, 64'h1111_1111_1111_1111, 8'h0F, 1'b0, 64'h0},            // R6/R7 store hit
    '{1'b0, 34'h0A068, 64'h0, 8'h00, 1'b0,
      merge(mem_word(34'h0A068), 64'h1111_1111_1111_1111, 8'h0F)},               // R7 merged
    '{1'b1, 34'h0A078, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, 1'b0, 64'h0},
    '{1'b0, 34'h0A078, 64'h0, 8'h00, 1'b0, 64'hDEAD_BEEF_0BAD_F00D},
    '{1'b1, 34'h0C060, 64'h7777_7777_7777_7777, 8'hFF, 1'b0, 64'h0},            // R8 store miss
    '{1'b0, 34'h0A060, 64'h0, 8'h00, 1'b0, mem_word(34'h0A060)},                 // R8 line intact
    '{1'b0, 34'h0C060, 64'h0, 8'h00, 1'b1, mem_word(34'h0C060)},                 // R5 conflict
    '{1'b0, 34'h0A068, 64'h0, 8'h00, 1'b1, mem_word(34'h0A068)},                 // R5 evicted
    '{1'b0, 34'h3_FFFF_FFF8, 64'h0, 8'h00, 1'b1, mem_word(34'h3_FFFF_FFF8)},     // R1 top line
    '{1'b0, 34'h3_FFFF_FFE0, 64'h0, 8'h00, 1'b0, mem_word(34'h3_FFFF_FFE0)},
    '{1'b0, 34'h0_0000_0010, 64'h0, 8'h00, 1'b1, mem_word(34'h0_0000_0010)},     // R1 line 0
    '{1'b1, 34'h3_FFFF_FFE0, 64'hA5A5_A5A5_A5A5_A5A5, 8'h81, 1'b0, 64'h0},
    '{1'b0, 34'h3_FFFF_FFE0, 64'h0, 8'h00, 1'b0,
      merge(mem_word(34'h3_FFFF_FFE0), 64'hA5A5_A5A5_A5A5_A5A5, 8'h81)}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // backing memory: answers each fetch with four beats after a short delay
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        fills++;
        fill_addr = mem_rd_addr;
        repeat (2) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_word(fill_addr + 34'(8 * b));
          @(negedge clk);
        end
        mem_rd_valid = 1'b0;
      end
    end
  end

  // issue one request; returns whether a load responded at once, and its data
  task automatic issue(input logic wr, input logic [33:0] a, input logic [63:0] wd,
                       input logic [7:0] be, output logic quick, output logic [63:0] rd);
    int n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = wr; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    #1;
    while (!cpu_ready && n < 100) begin @(negedge clk); #1; n++; end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    quick = wr ? wb_push : cpu_rvalid;
    rd = cpu_rdata;
    if (wr) begin
      chk("R6 push", {wb_push, wb_addr}, {1'b1, a});
      chk("R6 data", wb_data, wd);
      chk("R6 be", {56'h0, wb_be}, {56'h0, be});
    end else if (!quick) begin
      n = 0;
      while (!cpu_rvalid && n < 100) begin @(negedge clk); n++; end
      rd = cpu_rdata;
      chk("R4 response", {63'h0, cpu_rvalid}, 64'h1);
    end
  endtask

  initial begin
    logic q;
    logic [63:0] d;
    int f0;
    repeat (3) @(negedge clk);
    chk("R2 reset ready", {63'h0, cpu_ready}, 64'h1);
    chk("R2 reset outputs", {61'h0, cpu_rvalid, mem_rd_req, wb_push}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      f0 = fills;
      issue(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].be, q, d);
      if (VEC[i].wr) begin
        chk("R8 store fetches nothing", 64'(fills - f0), 64'h0);
      end else begin
        chk("R3 hit latency", {63'h0, q}, {63'h0, !VEC[i].miss});
        chk("R3 load data", d, VEC[i].exp);
        chk("R4 fetch count", 64'(fills - f0), {63'h0, VEC[i].miss});
        if (VEC[i].miss) chk("R4 fetch address", {30'h0, fill_addr}, {30'h0, VEC[i].addr[33:5], 5'h0});
      end
    end

    // R2: reset mid-run invalidates resident lines
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    f0 = fills;
    issue(1'b0, 34'h3_FFFF_FFE0, 64'h0, 8'h0, q, d);
    chk("R2 miss after reset", {63'h0, q}, 64'h0);
    chk("R2 refetched data", d, mem_word(34'h3_FFFF_FFE0));
    chk("R2 fetch count", 64'(fills - f0), 64'h1);

    // R11: busy while refill runs
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 34'h1_0000_0040;
    @(posedge clk); @(negedge clk);
    chk("R11 ready low in lookup", {63'h0, cpu_ready}, 64'h0);
    @(negedge clk); @(negedge clk);
    chk("R11 ready low in refill", {63'h0, cpu_ready}, 64'h0);
    cpu_req = 1'b0;
    while (!cpu_rvalid) @(negedge clk);
    chk("R10 data after refill", cpu_rdata, mem_word(34'h1_0000_0040));
    @(negedge clk);
    chk("R10 single response", {63'h0, cpu_rvalid}, 64'h0);

    // R9: store held while write buffer full, loads still go
    @(negedge clk);
    wb_full = 1'b1;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 34'h1_0000_0048;
    cpu_wdata = 64'h0123_4567_89AB_CDEF; cpu_be = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9 ready low when full", {63'h0, cpu_ready}, 64'h0);
      @(negedge clk);
      chk("R9 no push when full", {63'h0, wb_push}, 64'h0);
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
    issue(1'b0, 34'h1_0000_0040, 64'h0, 8'h0, q, d);
    chk("R9 load accepted while full", {63'h0, q}, 64'h1);
    wb_full = 1'b0;
    issue(1'b1, 34'h1_0000_0048, 64'h0123_4567_89AB_CDEF, 8'hFF, q, d);
    issue(1'b0, 34'h1_0000_0048, 64'h0, 8'h0, q, d);
    chk("R9 store applied after release", d, 64'h0123_4567_89AB_CDEF);

    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule